// File: doc/BRIEF.md
# Cascadable FIFO Slice with Token Handoff

This block is one segment of a deep FIFO made by chaining identical segments in a ring. All segments share the write stream, the read stream and the reset. Each segment owns two tokens: one allows it to accept writes and one allows it to supply reads. It does so only while it holds the matching token. When a segment accepts a write into its last physical location, it raises a one-cycle write-pass pulse. When it supplies a read from its last location, it raises a read-pass pulse. The next segment in the ring takes the token from that pulse, and its next operation uses its own location zero. Data therefore leaves the chain in the order it entered, across segment boundaries.

Both stream sides use valid/ready handshakes. On the write side, the source holds `wr_valid` and `wr_data` stable until a cycle in which `wr_ready` is high; a write is transferred on any clock edge where both are high. A segment without the write token, or one that is full, keeps `wr_ready` low, so the composite ready of the chain is the OR of the segment readies. On the read side, `rd_valid` is high only in the segment that holds the read token and has data; the sink takes a word on any edge where `rd_valid` and `rd_ready` are both high. Segments without the read token drive `rd_data` to zero, so the data outputs can be OR-combined.

One segment has `first_load_n` tied low and starts with both tokens. The others tie it high. Each segment reports active-low empty and full flags, which the system combines into composite flags.

Top module: `fifo_chain_slice`

## Requirements
- R1: After reset, a segment with `first_load_n` low has `wr_ready` high. A segment with `first_load_n` high has `wr_ready` low. Every segment has `rd_valid` low, `empty_n` low and `full_n` high.
- R2: `wr_ready` is high exactly when the segment holds the write token and holds fewer than DEPTH words. Each accepted write stores `wr_data` at the next location in order 0, 1, …, DEPTH-1.
- R3: `xo_wr` is high in the same cycle as the handshake that writes location DEPTH-1. After that edge the segment no longer holds the write token.
- R4: `rd_valid` is high exactly when the segment holds the read token and is not empty. `rd_data` then shows the oldest stored word, and each read handshake advances to the next word.
- R5: `xo_rd` is high in the same cycle as the handshake that reads location DEPTH-1. After that edge the segment no longer holds the read token.
- R6: A high `xi_wr` (or `xi_rd`) at a clock edge gives the segment the write (or read) token. Its next write (or read) uses location 0.
- R7: A segment without the write token ignores `wr_valid`, so nothing is stored. A segment without the read token ignores `rd_ready`, so its contents are unchanged, and it drives `rd_data` to zero.
- R8: `empty_n` is low exactly when the segment holds no words. `full_n` is low exactly when it holds DEPTH words.
- R9: A ring of three segments returns every accepted word in write order over more than three times DEPTH words, with writes and reads interleaved.
- R10: A write and a read accepted by the same segment in the same cycle leave its word count unchanged, and both transfers complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| first_load_n | input | 1 | Low marks the segment that starts with both tokens |
| wr_valid | input | 1 | Shared write-stream valid |
| wr_ready | output | 1 | Segment accepts a write this cycle |
| wr_data | input | WIDTH | Shared write-stream data |
| rd_valid | output | 1 | Segment offers a word this cycle |
| rd_ready | input | 1 | Shared read-stream ready |
| rd_data | output | WIDTH | Oldest word, zero when not offering |
| xi_wr | input | 1 | Write-token grant from the previous segment |
| xi_rd | input | 1 | Read-token grant from the previous segment |
| xo_wr | output | 1 | Write-token pass pulse to the next segment |
| xo_rd | output | 1 | Read-token pass pulse to the next segment |
| empty_n | output | 1 | Active-low empty flag |
| full_n | output | 1 | Active-low full flag |

## Verification
The bench builds three segments with WIDTH 9 and DEPTH 4 and connects them in a ring. A shallow depth makes token handoffs frequent: a stream of a few dozen words wraps the write and read tokens around the whole ring several times. This exercises the wrap from the last segment back to the first, the full condition of each segment, and the reader catching up with the writer inside one segment. With only four locations per segment, a write and a read often meet in the same segment in the same cycle.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

  // Advance a ring index, wrapping after the last physical location.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/chain_ring_ptr.sv
module chain_ring_ptr
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [PTR_W-1:0] ptr,
  output logic             at_last
);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (step) ptr <= PTR_W'(ring_next(32'(ptr), DEPTH));
  end

  assign at_last = (32'(ptr) == DEPTH - 1);

  // R2: pointer stays inside the physical array
  assert_ptr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr) < DEPTH);

endmodule

// File: rtl/chain_token_keeper.sv
module chain_token_keeper (
  input  logic clk,
  input  logic rst_n,
  input  logic start_owner,
  input  logic grant,
  input  logic release_evt,
  output logic own
);

  always_ff @(posedge clk) begin
    if (!rst_n) own <= start_owner;
    else        own <= (own & ~release_evt) | grant;
  end

  // R3 / R5: token leaves after the pass event
  assert_token_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && !grant) |=> !own);

  // R6: a grant pulse hands over the token
  assert_token_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> own);

endmodule

// File: rtl/chain_store.sv
module chain_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_chain_slice.sv
module fifo_chain_slice #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_load_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  input  logic             xi_wr,
  input  logic             xi_rd,
  output logic             xo_wr,
  output logic             xo_rd,
  output logic             empty_n,
  output logic             full_n
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             wr_own, rd_own;
  logic             wr_fire, rd_fire;
  logic             wr_last, rd_last;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [WIDTH-1:0] store_q;
  logic [CNT_W-1:0] count_q;
  logic             full, empty;

  assign full     = (count_q == CNT_W'(DEPTH));
  assign empty    = (count_q == '0);
  assign wr_ready = wr_own & ~full;
  assign rd_valid = rd_own & ~empty;
  assign wr_fire  = wr_valid & wr_ready;
  assign rd_fire  = rd_ready & rd_valid;
  assign xo_wr    = wr_fire & wr_last;
  assign xo_rd    = rd_fire & rd_last;
  assign rd_data  = rd_valid ? store_q : '0;
  assign empty_n  = ~empty;
  assign full_n   = ~full;

  chain_token_keeper u_wr_tok (
    .clk(clk), .rst_n(rst_n), .start_owner(~first_load_n),
    .grant(xi_wr), .release_evt(xo_wr), .own(wr_own)
  );

  chain_token_keeper u_rd_tok (
    .clk(clk), .rst_n(rst_n), .start_owner(~first_load_n),
    .grant(xi_rd), .release_evt(xo_rd), .own(rd_own)
  );

  chain_ring_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n), .step(wr_fire), .ptr(wr_ptr), .at_last(wr_last)
  );

  chain_ring_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .step(rd_fire), .ptr(rd_ptr), .at_last(rd_last)
  );

  chain_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .we(wr_fire), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(store_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else if (wr_fire && !rd_fire) count_q <= count_q + 1'b1;
    else if (rd_fire && !wr_fire) count_q <= count_q - 1'b1;
  end

  // R8: occupancy never exceeds the array
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R8: full appears only through an accepted write
  assert_full_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_n) |-> $past(wr_fire));

  // R8: empty appears only through an accepted read
  assert_empty_by_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty_n) |-> $past(rd_fire));

  // R6: a write grant finds the write pointer at location zero
  assert_wr_grant_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xi_wr |-> (wr_ptr == '0));

  // R6: a read grant finds the read pointer at location zero
  assert_rd_grant_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xi_rd |-> (rd_ptr == '0));

endmodule

// File: tb/fifo_chain_slice_tb.sv
module fifo_chain_slice_tb;

  localparam int W = 9;
  localparam int D = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, wr_valid, rd_ready;
  logic [W-1:0] wr_data;
  logic [2:0]   wr_rdy, rd_vld, xo_w, xo_r, emp_n, ful_n;
  logic [W-1:0] rdat0, rdat1, rdat2;
  logic [W-1:0] rd_bus;
  logic         any_wr_rdy, any_rd_vld;

  assign rd_bus     = rdat0 | rdat1 | rdat2;
  assign any_wr_rdy = |wr_rdy;
  assign any_rd_vld = |rd_vld;

  fifo_chain_slice #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .first_load_n(1'b0),
    .wr_valid(wr_valid), .wr_ready(wr_rdy[0]), .wr_data(wr_data),
    .rd_valid(rd_vld[0]), .rd_ready(rd_ready), .rd_data(rdat0),
    .xi_wr(xo_w[2]), .xi_rd(xo_r[2]), .xo_wr(xo_w[0]), .xo_rd(xo_r[0]),
    .empty_n(emp_n[0]), .full_n(ful_n[0])
  );

  fifo_chain_slice #(.WIDTH(W), .DEPTH(D)) u_s1 (
    .clk(clk), .rst_n(rst_n), .first_load_n(1'b1),
    .wr_valid(wr_valid), .wr_ready(wr_rdy[1]), .wr_data(wr_data),
    .rd_valid(rd_vld[1]), .rd_ready(rd_ready), .rd_data(rdat1),
    .xi_wr(xo_w[0]), .xi_rd(xo_r[0]), .xo_wr(xo_w[1]), .xo_rd(xo_r[1]),
    .empty_n(emp_n[1]), .full_n(ful_n[1])
  );

  fifo_chain_slice #(.WIDTH(W), .DEPTH(D)) u_s2 (
    .clk(clk), .rst_n(rst_n), .first_load_n(1'b1),
    .wr_valid(wr_valid), .wr_ready(wr_rdy[2]), .wr_data(wr_data),
    .rd_valid(rd_vld[2]), .rd_ready(rd_ready), .rd_data(rdat2),
    .xi_wr(xo_w[1]), .xi_rd(xo_r[1]), .xo_wr(xo_w[2]), .xo_rd(xo_r[2]),
    .empty_n(emp_n[2]), .full_n(ful_n[2])
  );

  int           checks = 0;
  int           fails  = 0;
  int           pushes = 0;
  int           pops   = 0;
  int           both_same = 0;
  bit           finished = 0;
  logic [W-1:0] sb_q [$];
  logic [W-1:0] next_val;
  logic [2:0]   seen_xo_w, seen_xo_r;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Monitor: pop the expected word and compare with the composite read bus.
  task automatic monitor_read(input string req);
    logic [W-1:0] exp_v;
    if (sb_q.size() == 0) begin
      chk(req, "read with empty scoreboard", 1, 0);
    end else begin
      exp_v = sb_q.pop_front();
      pops++;
      chk(req, "read data order", int'(rd_bus), int'(exp_v));
    end
  endtask

  // Driver: present one cycle of stimulus; record accepted writes.
  task automatic drive_cycle(input bit wv, input bit rr, input string req);
    bit wfire, rfire;
    @(negedge clk);
    wr_valid = wv;
    wr_data  = next_val;
    rd_ready = rr;
    #1;
    wfire = wv && any_wr_rdy;
    rfire = rr && any_rd_vld;
    seen_xo_w = xo_w;
    seen_xo_r = xo_r;
    if (wfire && rfire && ((wr_rdy & rd_vld) != 3'b000)) both_same++;
    if (wfire) begin
      sb_q.push_back(next_val);
      next_val = next_val + 9'd37;
      pushes++;
    end
    if (rfire) monitor_read(req);
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("WATCHDOG", "run did not complete", 0, 1);
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    wr_valid = 1'b0;
    rd_ready = 1'b0;
    wr_data  = '0;
    next_val = 9'd5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state of all three segments
    chk("R1", "wr_ready after reset", int'(wr_rdy), 1);
    chk("R1", "rd_valid after reset", int'(rd_vld), 0);
    chk("R1", "empty_n after reset", int'(emp_n), 0);
    chk("R1", "full_n after reset", int'(ful_n), 7);

    // Fill segment 0; the pass pulse comes with the last write (R3)
    for (int i = 0; i < D; i++) begin
      drive_cycle(1'b1, 1'b0, "R2");
      chk("R3", "xo_wr of segment 0", int'(seen_xo_w[0]), (i == D - 1) ? 1 : 0);
    end
    chk("R8", "segment 0 full_n", int'(ful_n[0]), 0);
    chk("R2", "segment 0 wr_ready when full", int'(wr_rdy[0]), 0);
    chk("R6", "write token moved to segment 1", int'(wr_rdy), 2);
    chk("R7", "segments 1,2 ignored earlier writes (empty_n)", int'(emp_n[2:1]), 0);
    chk("R7", "segment 1 rd_data without read token", int'(rdat1), 0);
    chk("R4", "segment 0 offers data", int'(rd_vld), 1);

    // Fill segment 1
    for (int i = 0; i < D; i++) begin
      drive_cycle(1'b1, 1'b0, "R2");
      chk("R3", "xo_wr of segment 1", int'(seen_xo_w[1]), (i == D - 1) ? 1 : 0);
    end
    chk("R6", "write token moved to segment 2", int'(wr_rdy), 4);

    // Drain segment 0; the read pass pulse comes with the last read (R5)
    for (int i = 0; i < D; i++) begin
      drive_cycle(1'b0, 1'b1, "R4");
      chk("R5", "xo_rd of segment 0", int'(seen_xo_r[0]), (i == D - 1) ? 1 : 0);
    end
    chk("R8", "segment 0 empty_n after drain", int'(emp_n[0]), 0);
    chk("R8", "segment 0 full_n after drain", int'(ful_n[0]), 1);
    chk("R6", "read token moved to segment 1", int'(rd_vld), 2);
    chk("R7", "segment 1 kept its words during foreign reads", int'(ful_n[1]), 0);

    // Interleaved streaming around the ring (R9, R10)
    for (int k = 0; k < 400 && pushes < 12 * D; k++) begin
      drive_cycle(($urandom % 4) != 0, ($urandom % 3) != 0, "R9");
    end
    for (int k = 0; k < 200 && sb_q.size() != 0; k++) begin
      drive_cycle(1'b0, 1'b1, "R9");
    end
    chk("R9", "scoreboard drained", sb_q.size(), 0);
    chk("R9", "words returned beyond three segment depths", int'(pops > 3 * D), 1);
    chk("R8", "all segments empty after drain", int'(emp_n), 0);
    chk("R10", "same-segment write and read occurred", int'(both_same > 0), 1);

    // Directed same-cycle write and read in one segment (R10)
    drive_cycle(1'b1, 1'b0, "R10");
    drive_cycle(1'b1, 1'b1, "R10");
    chk("R10", "one word remains after paired transfer", int'(emp_n != 3'b000), 1);
    chk("R10", "that word is offered", int'(any_rd_vld), 1);
    drive_cycle(1'b0, 1'b1, "R10");
    chk("R10", "empty after final read", int'(emp_n), 0);
    chk("R10", "scoreboard empty at end", sb_q.size(), 0);

    finish_run();
  end

endmodule